// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

A slave can be left mid-byte when a transfer is cut off, for example by a reset or by a firmware reload. It then holds SDA low, and sometimes the lines sit high but the slave's state machine is still out of step with the master. This block frees the bus. It takes over both open-drain lines and plays a fixed pattern on them. The pattern is one START, then nine SCL pulses that clock out any byte the slave has left, then a second START, then a STOP. After that every slave is idle and listening for a fresh address.

A one-cycle `start` pulse begins the sequence. The block does not look at the bus first, so the same pattern runs whether SDA is stuck low or stuck high. Every level change is held for a programmable number of system clocks. While `busy` is high the sequencer owns both pull-down enables. Outside a recovery, the enables from the normal I2C controller pass through unchanged. A one-cycle `done` marks the point where the pins return to that controller.

Top module: `busfree_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `busy` and `done` are 0 and both pull outputs follow the controller inputs.
- R2: A `start` seen at a clock edge while `busy` is 0 makes `busy` 1 after that edge. No bus level is sampled first.
- R3: The opening steps, with each line written as released(1) or pulled(0), are: SCL 0/SDA 1, SCL 0/SDA 1, SCL 1/SDA 1, SCL 1/SDA 0. The last of these is a START: SDA falls while SCL is high.
- R4: Exactly nine clock pulses follow the opening. Each pulse is one low step and then two high steps, so the high phase is twice the low phase. SDA is pulled low for all of them.
- R5: The closing steps are: SCL 0/SDA 0, SCL 0/SDA 1, SCL 1/SDA 1, SCL 1/SDA 0 (the second START), SCL 0/SDA 0, SCL 1/SDA 0, SCL 1/SDA 1 (the STOP: SDA rises while SCL is high).
- R6: Each step lasts N clocks. N is the value on `half_cnt` at the accepting edge, and a value of 0 counts as 1. Changing `half_cnt` during a run has no effect, so `busy` stays high for exactly 38·N cycles.
- R7: `done` is high for exactly one cycle, in the first cycle after `busy` falls.
- R8: A `start` that arrives while `busy` is 1 is ignored. The step pattern and its timing do not change.
- R9: When `busy` is 0, `scl_pull`/`sda_pull` equal `ctl_scl_pull`/`ctl_sda_pull`. When `busy` is 1, the controller inputs are ignored. Pull outputs use 1 to mean drive the line low.
- R10: While `busy` stays high, no step boundary changes both lines in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to run one recovery sequence |
| half_cnt | input | CNT_W | Clocks per step (0 treated as 1) |
| ctl_scl_pull | input | 1 | Normal controller's SCL pull-low enable |
| ctl_sda_pull | input | 1 | Normal controller's SDA pull-low enable |
| busy | output | 1 | Sequencer owns the pins |
| done | output | 1 | One-cycle pulse when the pins are handed back |
| scl_pull | output | 1 | SCL pull-low enable to the pad |
| sda_pull | output | 1 | SDA pull-low enable to the pad |

## Verification
The hardest situation to reach from the ports is a `start` that lands while a run is already in progress. It is made harder when the `half_cnt` and controller inputs change at the same moment. The bench reaches it with one run that pulses `start` every few cycles and toggles both controller enables, and it changes `half_cnt` partway through. The cycle-by-cycle reference model must then show the same 38·N waveform as a quiet run. A second case holds `start` high across two full sequences. This puts a request on the very cycle `done` is shown, which checks that the pins return to the controller and a new run is accepted one cycle later. A pull-up bus model counts START, STOP and SCL rising edges for each run.

// File: rtl/busfree_pkg.sv
package busfree_pkg;

    // Line levels as seen on the bus: 1 = released (pulled up), 0 = pulled low
    typedef struct packed {
        logic scl;
        logic sda;
    } lines_t;

    typedef enum logic {ST_IDLE, ST_RUN} seq_state_e;

    localparam int unsigned OPEN_STEPS    = 4;
    localparam int unsigned CLOSE_STEPS   = 7;
    localparam int unsigned STEPS_PER_CLK = 3;

    function automatic int unsigned total_steps(input int unsigned nclk);
        return OPEN_STEPS + STEPS_PER_CLK * nclk + CLOSE_STEPS;
    endfunction

    // Bus levels for a given step index of the recovery pattern
    function automatic lines_t step_lines(input int unsigned idx, input int unsigned nclk);
        lines_t r;
        int unsigned k;
        r = {1'b1, 1'b1};
        if (idx < OPEN_STEPS) begin
            case (idx)
                0, 1:    r = {1'b0, 1'b1};
                2:       r = {1'b1, 1'b1};
                default: r = {1'b1, 1'b0};   // START edge
            endcase
        end else if (idx < OPEN_STEPS + STEPS_PER_CLK * nclk) begin
            k = (idx - OPEN_STEPS) % STEPS_PER_CLK;
            r.scl = (k != 0);                // one low step, two high steps
            r.sda = 1'b0;
        end else begin
            k = idx - OPEN_STEPS - STEPS_PER_CLK * nclk;
            case (k)
                0:       r = {1'b0, 1'b0};
                1:       r = {1'b0, 1'b1};
                2:       r = {1'b1, 1'b1};
                3:       r = {1'b1, 1'b0};   // second START
                4:       r = {1'b0, 1'b0};
                5:       r = {1'b1, 1'b0};
                default: r = {1'b1, 1'b1};   // STOP edge
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/busfree_timer.sv
module busfree_timer #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             run,
    input  logic [CNT_W-1:0] half_in,
    output logic             tick
);
    logic [CNT_W-1:0] hold_q;
    logic [CNT_W-1:0] cnt_q;

    assign tick = run && (cnt_q == hold_q - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= CNT_W'(1);
            cnt_q  <= '0;
        end else if (load) begin
            hold_q <= (half_in == '0) ? CNT_W'(1) : half_in;
            cnt_q  <= '0;
        end else if (run) begin
            if (tick) cnt_q <= '0;
            else      cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/busfree_stepper.sv
module busfree_stepper
    import busfree_pkg::*;
#(
    parameter int unsigned NCLK   = 9,
    parameter int unsigned STEP_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              tick,
    output logic              busy,
    output logic              done,
    output logic              load,
    output logic [STEP_W-1:0] step
);
    localparam int unsigned LAST = total_steps(NCLK) - 1;

    seq_state_e        st_q;
    logic              done_q;
    logic [STEP_W-1:0] step_q;

    assign busy = (st_q == ST_RUN);
    assign done = done_q;
    assign step = step_q;
    assign load = start && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b0;
            step_q <= '0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        st_q   <= ST_RUN;
                        step_q <= '0;
                    end
                end
                ST_RUN: begin
                    if (tick) begin
                        if (step_q == STEP_W'(LAST)) begin
                            st_q   <= ST_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            step_q <= step_q + STEP_W'(1);
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/busfree_pinmux.sv
module busfree_pinmux
    import busfree_pkg::*;
(
    input  logic   busy,
    input  lines_t seq_lv,
    input  logic   ctl_scl_pull,
    input  logic   ctl_sda_pull,
    output logic   scl_pull,
    output logic   sda_pull
);
    logic [1:0] seq_pull;
    logic [1:0] ctl_pull;
    logic [1:0] out_pull;

    assign seq_pull = ~{seq_lv.scl, seq_lv.sda};
    assign ctl_pull = {ctl_scl_pull, ctl_sda_pull};

    for (genvar i = 0; i < 2; i++) begin : g_line
        assign out_pull[i] = busy ? seq_pull[i] : ctl_pull[i];
    end

    assign scl_pull = out_pull[1];
    assign sda_pull = out_pull[0];
endmodule

// File: rtl/busfree_seq.sv
module busfree_seq
    import busfree_pkg::*;
#(
    parameter int unsigned NCLK  = 9,
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] half_cnt,
    input  logic             ctl_scl_pull,
    input  logic             ctl_sda_pull,
    output logic             busy,
    output logic             done,
    output logic             scl_pull,
    output logic             sda_pull
);
    localparam int unsigned STEP_W = $clog2(total_steps(NCLK));

    logic              load;
    logic              tick;
    logic [STEP_W-1:0] step;
    lines_t            lv;

    assign lv = step_lines({{(32-STEP_W){1'b0}}, step}, NCLK);

    busfree_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .run     (busy),
        .half_in (half_cnt),
        .tick    (tick)
    );

    busfree_stepper #(.NCLK(NCLK), .STEP_W(STEP_W)) u_stp (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .tick  (tick),
        .busy  (busy),
        .done  (done),
        .load  (load),
        .step  (step)
    );

    busfree_pinmux u_mux (
        .busy         (busy),
        .seq_lv       (lv),
        .ctl_scl_pull (ctl_scl_pull),
        .ctl_sda_pull (ctl_sda_pull),
        .scl_pull     (scl_pull),
        .sda_pull     (sda_pull)
    );
endmodule

// File: rtl/busfree_chk.sv
module busfree_chk #(
    parameter int unsigned STEP_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              tick,
    input logic [STEP_W-1:0] step,
    input logic              scl_pull,
    input logic              sda_pull
);
    AST_RST_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !done)) else $error("reset state");  // R1

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> (busy && step == '0)) else $error("start not taken");  // R2

    AST_HOLD_STEP: assert property (@(posedge clk) disable iff (rst)
        (busy && !tick) |=> ($stable(scl_pull) && $stable(sda_pull))) else $error("step not held");  // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("done longer than one cycle");  // R7

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy))) else $error("done not at busy fall");  // R7

    AST_IGNORE_START: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !tick) |=> (busy && $stable(step))) else $error("start while busy acted");  // R8

    AST_ONE_LINE: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> !(($past(scl_pull) != scl_pull) && ($past(sda_pull) != sda_pull)))
        else $error("both lines changed");  // R10
endmodule

bind busfree_seq busfree_chk #(.STEP_W(STEP_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .tick     (tick),
    .step     (step),
    .scl_pull (scl_pull),
    .sda_pull (sda_pull)
);

// File: tb/sim_busfree_seq.sv
module sim_busfree_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] half = 16'd3;
    logic        ctl_scl = 1'b0;
    logic        ctl_sda = 1'b0;
    logic        busy, done, scl_pull, sda_pull;

    busfree_seq u0 (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .half_cnt     (half),
        .ctl_scl_pull (ctl_scl),
        .ctl_sda_pull (ctl_sda),
        .busy         (busy),
        .done         (done),
        .scl_pull     (scl_pull),
        .sda_pull     (sda_pull)
    );

    always #2ns clk = ~clk;

    typedef struct {
        bit    busy;
        bit    done;
        bit    idle;
        bit    scl;
        bit    sda;
        string tag;
    } exp_t;

    exp_t q[$];
    int n_vec = 0, n_bad = 0, cyc = 0;
    int starts = 0, stops = 0, rises = 0, both = 0, busy_cyc = 0;
    bit pv_busy = 1'b0, pv_scl = 1'b1, pv_sda = 1'b1;

    task automatic push_lv(bit s, bit d, int n, string t);
        for (int i = 0; i < n; i++) q.push_back('{1'b1, 1'b0, 1'b0, s, d, t});
    endtask

    // expected waveform built from the requirement text (levels: 1 = released)
    task automatic build(int unsigned h);
        int n;
        bit o_scl[4] = '{0, 0, 1, 1};
        bit o_sda[4] = '{1, 1, 1, 0};
        bit c_scl[7] = '{0, 0, 1, 1, 0, 1, 1};
        bit c_sda[7] = '{0, 1, 1, 0, 0, 0, 1};
        n = (h == 0) ? 1 : int'(h);
        for (int i = 0; i < 4; i++) push_lv(o_scl[i], o_sda[i], n, "R3");
        for (int p = 0; p < 9; p++) begin
            push_lv(1'b0, 1'b0, n, "R4");
            push_lv(1'b1, 1'b0, 2 * n, "R4");
        end
        for (int i = 0; i < 7; i++) push_lv(c_scl[i], c_sda[i], n, "R5");
        q.push_back('{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R7"});
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    // reference model, compared every cycle
    always @(posedge clk) begin
        exp_t e;
        bit es, ed, sl, dl;
        #1ns;
        if (rst) begin
            q.delete();
            e = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R1"};
        end else if (q.size() > 0) begin
            e = q.pop_front();
        end else if (start) begin
            build(half);
            e = q.pop_front();
        end else begin
            e = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R9"};
        end
        es = e.idle ? ctl_scl : !e.scl;
        ed = e.idle ? ctl_sda : !e.sda;
        n_vec++;
        if (busy !== e.busy || done !== e.done || scl_pull !== es || sda_pull !== ed) begin
            n_bad++;
            $display("FAIL %s: busy,done,scl_pull,sda_pull got %b%b%b%b expected %b%b%b%b",
                     e.tag, busy, done, scl_pull, sda_pull, e.busy, e.done, es, ed);
        end
        // open-drain bus with pull-ups
        sl = !scl_pull;
        dl = !sda_pull;
        if (busy) busy_cyc++;
        if (pv_busy && busy) begin
            if (sl != pv_scl && dl != pv_sda) both++;
            if (pv_scl && sl && pv_sda && !dl) starts++;
            if (pv_scl && sl && !pv_sda && dl) stops++;
            if (!pv_scl && sl) rises++;
        end
        pv_busy = busy;
        pv_scl  = sl;
        pv_sda  = dl;
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clear_counts();
        starts = 0; stops = 0; rises = 0; both = 0; busy_cyc = 0;
    endtask

    task automatic run(int h, bit noisy, string len_tag);
        int n;
        n = (h == 0) ? 1 : h;
        @(negedge clk);
        clear_counts();
        half  = 16'(h);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2", int'(busy), 1);
        for (int i = 0; i < 38 * n + 3; i++) begin
            @(negedge clk);
            if (noisy && i < 38 * n - 3) begin
                start   = (i % 5 == 0);          // R8: requests while busy
                ctl_scl = i[0];                  // R9: controller ignored
                ctl_sda = i[1];
                if (i == 7) half = 16'd9;        // R6: late change ignored
            end else begin
                start   = 1'b0;
                ctl_scl = 1'b0;
                ctl_sda = 1'b0;
            end
        end
        chk(starts == 2, "R3", starts, 2);
        chk(stops == 1, "R5", stops, 1);
        chk(rises == 12, "R4", rises, 12);
        chk(both == 0, "R10", both, 0);
        chk(busy_cyc == 38 * n, len_tag, busy_cyc, 38 * n);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done, "R1", int'({busy, done}), 0);
        // idle pass-through of controller enables
        for (int i = 0; i < 4; i++) begin
            ctl_scl = i[0];
            ctl_sda = i[1];
            @(negedge clk);
            chk(scl_pull == ctl_scl && sda_pull == ctl_sda, "R9",
                int'({scl_pull, sda_pull}), int'({ctl_scl, ctl_sda}));
        end
        ctl_scl = 1'b0;
        ctl_sda = 1'b0;
        run(3, 1'b0, "R6");
        run(1, 1'b0, "R6");
        run(0, 1'b0, "R6");
        run(4, 1'b1, "R8");
        // start held high across two sequences: second accepted after done
        @(negedge clk);
        clear_counts();
        half  = 16'd2;
        start = 1'b1;
        repeat (80) @(negedge clk);
        start = 1'b0;
        repeat (80) @(negedge clk);
        chk(starts == 4, "R7", starts, 4);
        chk(stops == 2, "R5", stops, 2);
        chk(busy_cyc == 152, "R7", busy_cyc, 152);
        repeat (5) @(negedge clk);
        summary();
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected at most %0d", cyc, 50000);
            summary();
            $finish;
        end
    end
endmodule